// File: doc/BRIEF.md
# Converter Startup and Fault Sequencer

This block is the digital supervisor of a two-phase series-capacitor step-down converter. It runs on the converter's oscillator clock and takes in the decisions of the analog side: the enable input, input lockout flags, die temperature flag, a precharge-complete flag, window comparator results for the feedback node and the series capacitor, and per-phase low-side overcurrent samples. From these it runs the power-up order (series capacitor precharge, reference ramp, regulation) and chooses the fault response and recovery path for each kind of fault.

A three-bit setup code selects one of three oscillator frequencies and a soft-start length. The code is captured while the converter is off and stays frozen until enable is dropped. Soft-start and hiccup windows are counted in oscillator cycles, so their wall-clock length scales with the selected frequency. The outputs gate the power switches, the precharge current source, the reference ramp, the frequency lock loop, the series capacitor bleed resistor and the power-good pull-down.

Top module: `conv_supervisor`

## Requirements
- R1: While `en` is low or `vin_uv` is high, `sw_en`, `pchg_en`, `ramp_en`, `pll_en`, `bleed_en` and `pgood` are all low. One cycle after `en` is high with `vin_uv` low (and `vin_ov`, `therm_sd` low), `pchg_en` goes high; `ramp_en` rises only on the cycle after `pchg_done` is seen during precharge.
- R2: `cfg_code` is captured only while the block is off; a change of `cfg_code` after start-up has no effect on `osc_sel` or on the soft-start length until `en` is cycled.
- R3: Code mapping: codes 0, 1, 2 give `osc_sel` = 0 (lowest frequency); codes 3, 4 give `osc_sel` = 1; codes 5, 6, 7 give `osc_sel` = 2 (highest frequency).
- R4: Soft start lasts exactly 2^SS_EXP0 cycles for codes 0, 3, 5, 2^SS_EXP1 cycles for codes 1, 4, 6, and 2^SS_EXP2 cycles for codes 2, 7 (`ramp_en` and `sw_en` high); the run state follows (`sw_en` and `pll_en` high).
- R5: During soft start `pgood` and `pll_en` stay low, and the feedback 90 %/110 % flags (`fb_lo90`, `fb_hi110`) are ignored.
- R6: `pgood` is high only in the run state, with `en` high, no input or thermal lockout, and both `fb_lo95` and `fb_hi105` low; it reacts to those flags in the same cycle.
- R7: Each cycle with a valid tripped sample from phase A or B and no valid clean sample counts one overcurrent trip; a valid clean sample clears the count; cycles with no valid sample leave it. The third consecutive trip drops `sw_en` and `pgood` on the next cycle, then a hiccup of 2^HIC_EXP cycles with everything off is followed by precharge.
- R8: In the run state `fb_lo90` or `fb_hi110` shuts the switches off and starts the hiccup wait, followed by precharge.
- R9: `scap_lo35` during soft start or run shuts down into the hiccup wait; recovery goes through precharge (waiting for `pchg_done`) and then soft start.
- R10: `scap_hi65` during soft start or run shuts down into the hiccup wait with `bleed_en` high for the whole wait; `bleed_en` is low in every other state, including the precharge that follows.
- R11: `vin_ov` or `therm_sd` while active turns every output off and holds there as long as either flag is set; when both clear the block goes straight to soft start with no hiccup and no precharge.
- R12: When faults coincide, enable low or `vin_uv` wins over `vin_ov`/`therm_sd`, which win over series capacitor faults, which win over feedback and overcurrent faults.
- R13: Out of reset the block is off with all outputs low and `osc_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| vin_uv | input | 1 | Input below lockout threshold |
| vin_ov | input | 1 | Input above overvoltage threshold |
| therm_sd | input | 1 | Die over temperature |
| pchg_done | input | 1 | Series capacitor reached half the input |
| fb_lo95 | input | 1 | Feedback below 95 % of reference |
| fb_hi105 | input | 1 | Feedback above 105 % of reference |
| fb_lo90 | input | 1 | Feedback below 90 % of reference |
| fb_hi110 | input | 1 | Feedback above 110 % of reference |
| scap_lo35 | input | 1 | Series capacitor below 35 % of input |
| scap_hi65 | input | 1 | Series capacitor above 65 % of input |
| oc_a_vld | input | 1 | Phase A current sample valid |
| oc_a_trip | input | 1 | Phase A sample over limit |
| oc_b_vld | input | 1 | Phase B current sample valid |
| oc_b_trip | input | 1 | Phase B sample over limit |
| cfg_code | input | 3 | Frequency and soft-start setup code |
| sw_en | output | 1 | Power switches allowed to switch |
| pchg_en | output | 1 | Precharge current source on |
| ramp_en | output | 1 | Reference ramp running |
| pll_en | output | 1 | Frequency lock loop active |
| bleed_en | output | 1 | Series capacitor bleed resistor on |
| pgood | output | 1 | Power good |
| osc_sel | output | 2 | Latched oscillator frequency choice |

## Verification
The bench builds the block with SS_EXP0/1/2 of 2, 3 and 4 and HIC_EXP of 5, so soft starts last 4, 8 and 16 cycles and a hiccup lasts 32. With these short windows the table walks every exit of the hiccup and soft-start counters, including the last count before each transition, and the sweep over all eight codes measures all three soft-start lengths exactly. OC_TRIPS stays at 3, so the consecutive-trip count and its reset by a clean sample are exercised as specified.

// File: rtl/conv_supervisor.sv
module conv_supervisor #(
  parameter int SS_EXP0  = 8,
  parameter int SS_EXP1  = 11,
  parameter int SS_EXP2  = 14,
  parameter int HIC_EXP  = 17,
  parameter int OC_TRIPS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       vin_uv,
  input  logic       vin_ov,
  input  logic       therm_sd,
  input  logic       pchg_done,
  input  logic       fb_lo95,
  input  logic       fb_hi105,
  input  logic       fb_lo90,
  input  logic       fb_hi110,
  input  logic       scap_lo35,
  input  logic       scap_hi65,
  input  logic       oc_a_vld,
  input  logic       oc_a_trip,
  input  logic       oc_b_vld,
  input  logic       oc_b_trip,
  input  logic [2:0] cfg_code,
  output logic       sw_en,
  output logic       pchg_en,
  output logic       ramp_en,
  output logic       pll_en,
  output logic       bleed_en,
  output logic       pgood,
  output logic [1:0] osc_sel
);

  localparam int SSMAX = (SS_EXP0 > SS_EXP1) ? ((SS_EXP0 > SS_EXP2) ? SS_EXP0 : SS_EXP2)
                                             : ((SS_EXP1 > SS_EXP2) ? SS_EXP1 : SS_EXP2);
  localparam int TW    = (HIC_EXP > SSMAX) ? HIC_EXP : SSMAX;
  localparam int OCW   = $clog2(OC_TRIPS + 1);
  localparam logic [TW-1:0]  HIC_LAST = {TW{1'b1}} >> (TW - HIC_EXP);
  localparam logic [OCW-1:0] OC_LAST  = OCW'(OC_TRIPS - 1);

  typedef enum logic [2:0] {S_OFF, S_PCHG, S_SOFT, S_RUN, S_HIC, S_HOLD} state_t;

  state_t         state, nxt;
  logic [2:0]     cfg_q;
  logic [TW-1:0]  tmr;
  logic [TW-1:0]  ss_last;
  logic [OCW-1:0] oc_cnt;
  logic           bleed_q;
  int             ss_e;

  wire lockout  = ~en | vin_uv;
  wire hold_in  = vin_ov | therm_sd;
  wire active   = (state == S_SOFT) | (state == S_RUN);
  wire trip_any = (oc_a_vld & oc_a_trip) | (oc_b_vld & oc_b_trip);
  wire ok_any   = (oc_a_vld & ~oc_a_trip) | (oc_b_vld & ~oc_b_trip);
  wire oc_fault = active & trip_any & ~ok_any & (oc_cnt == OC_LAST);
  wire cap_f    = active & (scap_lo35 | scap_hi65);
  wire out_f    = (state == S_RUN) & (fb_lo90 | fb_hi110);

  always_comb begin
    case (cfg_q)
      3'd0, 3'd1, 3'd2: osc_sel = 2'd0;
      3'd3, 3'd4:       osc_sel = 2'd1;
      default:          osc_sel = 2'd2;
    endcase
    case (cfg_q)
      3'd0, 3'd3, 3'd5: ss_e = SS_EXP0;
      3'd1, 3'd4, 3'd6: ss_e = SS_EXP1;
      default:          ss_e = SS_EXP2;
    endcase
    ss_last = {TW{1'b1}} >> (TW - ss_e);
  end

  always_comb begin
    nxt = state;
    if (lockout) nxt = S_OFF;
    else if (hold_in && state != S_OFF) nxt = S_HOLD;
    else begin
      case (state)
        S_OFF:  if (!hold_in) nxt = S_PCHG;
        S_PCHG: if (pchg_done) nxt = S_SOFT;
        S_SOFT: begin
          if (cap_f || oc_fault) nxt = S_HIC;
          else if (tmr == ss_last) nxt = S_RUN;
        end
        S_RUN:  if (cap_f || out_f || oc_fault) nxt = S_HIC;
        S_HIC:  if (tmr == HIC_LAST) nxt = S_PCHG;
        S_HOLD: nxt = S_SOFT;
        default: nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_OFF;
      cfg_q   <= '0;
      tmr     <= '0;
      oc_cnt  <= '0;
      bleed_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_OFF) cfg_q <= cfg_code;
      if (nxt != state) tmr <= '0;
      else if (state == S_SOFT || state == S_HIC) tmr <= tmr + 1'b1;
      if (!active || ok_any || nxt != state) oc_cnt <= '0;
      else if (trip_any) oc_cnt <= oc_cnt + 1'b1;
      if (nxt == S_HIC && state != S_HIC) bleed_q <= scap_hi65;
      else if (nxt != S_HIC) bleed_q <= 1'b0;
    end
  end

  assign sw_en    = active;
  assign pchg_en  = (state == S_PCHG);
  assign ramp_en  = (state == S_SOFT);
  assign pll_en   = (state == S_RUN);
  assign bleed_en = (state == S_HIC) & bleed_q;
  assign pgood    = (state == S_RUN) & ~lockout & ~hold_in & ~fb_lo95 & ~fb_hi105;

  AST_LOCKOUT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> (!sw_en && !pchg_en && !ramp_en && !pgood && !bleed_en)); // R1

  AST_RAMP_AFTER_PCHG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en) |-> (($past(pchg_en) && $past(pchg_done)) || $past(state == S_HOLD))); // R1

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_OFF && $past(state) != S_OFF) |-> $stable(osc_sel)); // R2

  AST_SOFT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !lockout && !hold_in && !scap_lo35 && !scap_hi65 && !trip_any && (fb_lo90 || fb_hi110))
      |=> (sw_en && !pgood)); // R5

  AST_PGOOD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (pll_en && !ramp_en && !fb_lo95 && !fb_hi105)); // R6

  AST_OC_THIRD_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && trip_any && !ok_any && oc_cnt == OC_LAST) |=> (!sw_en && !pgood)); // R7

  AST_BLEED_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    bleed_en |-> (!sw_en && !pchg_en && !ramp_en && !pgood)); // R10

  AST_HOLD_TO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state == S_HOLD) && $past(!lockout && !hold_in)) |-> ramp_en); // R11

endmodule

// File: tb/test_conv_supervisor.sv
`timescale 1ns/1ps
module test_conv_supervisor;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en, vin_uv, vin_ov, therm_sd, pchg_done;
  logic fb_lo95, fb_hi105, fb_lo90, fb_hi110, scap_lo35, scap_hi65;
  logic oc_a_vld, oc_a_trip, oc_b_vld, oc_b_trip;
  logic [2:0] cfg_code;
  logic sw_en, pchg_en, ramp_en, pll_en, bleed_en, pgood;
  logic [1:0] osc_sel;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  conv_supervisor #(.SS_EXP0(2), .SS_EXP1(3), .SS_EXP2(4), .HIC_EXP(5), .OC_TRIPS(3)) i_conv_supervisor (
    .clk(clk), .rst_n(rst_n), .en(en), .vin_uv(vin_uv), .vin_ov(vin_ov), .therm_sd(therm_sd),
    .pchg_done(pchg_done), .fb_lo95(fb_lo95), .fb_hi105(fb_hi105), .fb_lo90(fb_lo90),
    .fb_hi110(fb_hi110), .scap_lo35(scap_lo35), .scap_hi65(scap_hi65),
    .oc_a_vld(oc_a_vld), .oc_a_trip(oc_a_trip), .oc_b_vld(oc_b_vld), .oc_b_trip(oc_b_trip),
    .cfg_code(cfg_code), .sw_en(sw_en), .pchg_en(pchg_en), .ramp_en(ramp_en), .pll_en(pll_en),
    .bleed_en(bleed_en), .pgood(pgood), .osc_sel(osc_sel));

  typedef struct packed {
    logic [7:0] n;
    logic [4:0] ctl;
    logic [3:0] fb;
    logic [1:0] cap;
    logic [3:0] oc;
    logic [5:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 36;
  // ctl = {en,vin_uv,vin_ov,therm_sd,pchg_done}; fb = {lo95,hi105,lo90,hi110}
  // cap = {lo35,hi65}; oc = {a_vld,a_trip,b_vld,b_trip}
  // exp = {sw_en,pchg_en,ramp_en,pll_en,bleed_en,pgood}
  localparam vec_t VT [NV] = '{
    '{8'd2,  5'b00000, 4'b0000, 2'b00, 4'b0000, 6'b000000, 4'd1},  // R1 disabled
    '{8'd2,  5'b11000, 4'b0000, 2'b00, 4'b0000, 6'b000000, 4'd1},  // R1 lockout
    '{8'd1,  5'b10000, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd1},  // R1 precharge
    '{8'd3,  5'b10000, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd1},  // R1 waits
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b101000, 4'd1},  // R1 soft start
    '{8'd3,  5'b10001, 4'b1010, 2'b00, 4'b0000, 6'b101000, 4'd5},  // R5 masked
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b100101, 4'd4},  // R4 run
    '{8'd1,  5'b10001, 4'b1000, 2'b00, 4'b0000, 6'b100100, 4'd6},  // R6 low
    '{8'd1,  5'b10001, 4'b0100, 2'b00, 4'b0000, 6'b100100, 4'd6},  // R6 high
    '{8'd2,  5'b10001, 4'b0000, 2'b00, 4'b1100, 6'b100101, 4'd7},  // R7 two trips
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b1000, 6'b100101, 4'd7},  // R7 clean clears
    '{8'd2,  5'b10001, 4'b0000, 2'b00, 4'b0011, 6'b100101, 4'd7},  // R7 two trips B
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0011, 6'b000000, 4'd7},  // R7 third trip
    '{8'd31, 5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b000000, 4'd7},  // R7 hiccup last
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd7},  // R7 restart
    '{8'd4,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b101000, 4'd4},  // R4 last soft
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b100101, 4'd4},  // R4 run
    '{8'd1,  5'b10001, 4'b0000, 2'b01, 4'b0000, 6'b000010, 4'd10}, // R10 bleed
    '{8'd31, 5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b000010, 4'd10}, // R10 bleed held
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd10}, // R10 bleed off
    '{8'd5,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b100101, 4'd9},  // R9 run again
    '{8'd1,  5'b10001, 4'b0000, 2'b10, 4'b0000, 6'b000000, 4'd9},  // R9 cap low
    '{8'd32, 5'b10000, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd9},  // R9 precharge
    '{8'd5,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b100101, 4'd9},  // R9 run
    '{8'd1,  5'b10001, 4'b0101, 2'b00, 4'b0000, 6'b000000, 4'd8},  // R8 over
    '{8'd32, 5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd8},  // R8 restart
    '{8'd5,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b100101, 4'd8},  // R8 run
    '{8'd3,  5'b10101, 4'b0000, 2'b00, 4'b0000, 6'b000000, 4'd11}, // R11 input ov
    '{8'd2,  5'b10011, 4'b0000, 2'b00, 4'b0000, 6'b000000, 4'd11}, // R11 thermal
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b101000, 4'd11}, // R11 soft direct
    '{8'd1,  5'b10011, 4'b1010, 2'b01, 4'b0000, 6'b000000, 4'd12}, // R12 thermal wins
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b101000, 4'd12}, // R12 was hold
    '{8'd4,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b100101, 4'd12}, // R12 run
    '{8'd1,  5'b10001, 4'b1010, 2'b01, 4'b0000, 6'b000010, 4'd12}, // R12 cap wins
    '{8'd1,  5'b00101, 4'b0000, 2'b00, 4'b0000, 6'b000000, 4'd12}, // R12 enable wins
    '{8'd1,  5'b10001, 4'b0000, 2'b00, 4'b0000, 6'b010000, 4'd12}  // R12 was off
  };

  function automatic logic [1:0] exp_osc(input int c);
    return (c <= 2) ? 2'd0 : (c <= 4) ? 2'd1 : 2'd2;
  endfunction

  function automatic int exp_ss(input int c);
    case (c)
      0, 3, 5: return 4;
      1, 4, 6: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [5:0] outs();
    return {sw_en, pchg_en, ramp_en, pll_en, bleed_en, pgood};
  endfunction

  task automatic quiet();
    en = 0; vin_uv = 0; vin_ov = 0; therm_sd = 0; pchg_done = 0;
    {fb_lo95, fb_hi105, fb_lo90, fb_hi110} = '0;
    {scap_lo35, scap_hi65} = '0;
    {oc_a_vld, oc_a_trip, oc_b_vld, oc_b_trip} = '0;
  endtask

  task automatic soft_len(output int len);
    len = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (ramp_en) len++;
      if (pll_en) break;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    quiet();
    cfg_code = 3'd0;
    repeat (3) @(negedge clk);
    chk("R13 outputs in reset", outs(), 6'b000000);
    chk("R13 osc_sel in reset", osc_sel, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 outputs after reset", outs(), 6'b000000);

    for (int i = 0; i < NV; i++) begin
      {en, vin_uv, vin_ov, therm_sd, pchg_done} = VT[i].ctl;
      {fb_lo95, fb_hi105, fb_lo90, fb_hi110} = VT[i].fb;
      {scap_lo35, scap_hi65} = VT[i].cap;
      {oc_a_vld, oc_a_trip, oc_b_vld, oc_b_trip} = VT[i].oc;
      repeat (VT[i].n) @(negedge clk);
      chk($sformatf("R%0d vector %0d", VT[i].req, i), outs(), VT[i].exp);
    end

    // R3 R4: every code, frequency choice and soft-start length
    for (int c = 0; c < 8; c++) begin
      quiet();
      repeat (2) @(negedge clk);
      cfg_code = 3'(c);
      en = 1; pchg_done = 1;
      soft_len(len);
      chk($sformatf("R3 osc_sel code %0d", c), osc_sel, exp_osc(c));
      chk($sformatf("R4 soft length code %0d", c), len, exp_ss(c));
    end

    // R2: code change after start-up is ignored until enable cycles
    quiet();
    cfg_code = 3'd1;
    repeat (2) @(negedge clk);
    en = 1;
    @(negedge clk);
    cfg_code = 3'd7;
    @(negedge clk);
    pchg_done = 1;
    soft_len(len);
    chk("R2 osc_sel frozen", osc_sel, 2'd0);
    chk("R2 soft length frozen", len, 8);
    en = 0;
    repeat (2) @(negedge clk);
    en = 1;
    soft_len(len);
    chk("R2 osc_sel after enable cycle", osc_sel, 2'd2);
    chk("R2 soft length after enable cycle", len, 16);

    // R7: overcurrent during soft start, cycles without samples keep the count
    quiet();
    cfg_code = 3'd2;
    repeat (2) @(negedge clk);
    en = 1; pchg_done = 1;
    repeat (2) @(negedge clk);
    chk("R7 in soft start", outs(), 6'b101000);
    {oc_a_vld, oc_a_trip} = 2'b11;
    repeat (2) @(negedge clk);
    {oc_a_vld, oc_a_trip} = 2'b00;
    repeat (2) @(negedge clk);
    chk("R7 two trips, gap keeps running", outs(), 6'b101000);
    {oc_b_vld, oc_b_trip} = 2'b11;
    @(negedge clk);
    chk("R7 third trip in soft start", outs(), 6'b000000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule